// File: doc/BRIEF.md
# Regulator Start-Up and Fault-Retry Sequencer

This block is the digital start-up controller of a step-down switching regulator. It waits until the bias supply is good and the enable comparator reports that the enable line is above its disable threshold. It then waits a fixed settling delay and asks an external overcurrent set-point sampler to take its one sample. When the sampler answers, the block drives a reference DAC with a code that climbs in equal steps to full scale. At full scale the converter is in regulation.

An overcurrent flag during the ramp or during regulation turns the power stage off in the same cycle. The block then waits two dummy ramp-length periods with the gates off and starts a fresh real ramp. It does not ask for a new set-point sample on a retry. A short that is present at start-up therefore looks the same as a retry. A new sample is requested only after enable or the bias supply has been removed and restored.

All times are counted in system-clock cycles and set by parameters, so a simulation can use short values.

Top module: `softstart_seq`

## Requirements
- R1: While rst_ni is low and directly after it, sample_req_o, gate_en_o, in_reg_o and ref_code_o are all 0.
- R2: Start-up begins only when por_ok_i and en_i are both high. sample_req_o rises exactly DELAY_CYC+1 clock edges after the edge that first sees both high. gate_en_o stays 0 until then.
- R3: sample_req_o stays high until sample_done_i is seen high at a clock edge. After that edge sample_req_o is 0 and the ramp starts at code 0.
- R4: During the ramp, ref_code_o rises by one every STEP_CYC cycles, from 0 to STEPS. in_reg_o goes high in the cycle where ref_code_o first equals STEPS, and ref_code_o equals STEPS whenever in_reg_o is high.
- R5: During the ramp, gate_en_o is 1 only while ref_code_o >= prebias_i (unsigned compare). In regulation gate_en_o is 1 whatever the value of prebias_i, including values above STEPS.
- R6: A low en_i drops gate_en_o in the same cycle. After the next edge, ref_code_o and in_reg_o are 0. A later high en_i repeats the delay and the sample request, as in R2.
- R7: A low por_ok_i behaves the same as a low en_i, including a restart with a new sample request when it returns.
- R8: ocp_i high during regulation drops gate_en_o in the same cycle. For the next 2*STEPS*STEP_CYC cycles gate_en_o, ref_code_o and sample_req_o stay 0. A new ramp then starts at code 0 without a sample request.
- R9: ocp_i high at any point of the ramp, including the first real ramp, aborts it in the same way as R8 and starts the same two-period retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| por_ok_i | input | 1 | Bias supply above its power-on threshold |
| en_i | input | 1 | Enable comparator: line above the disable threshold |
| sample_done_i | input | 1 | Overcurrent set-point sampler has finished |
| ocp_i | input | 1 | Overcurrent detected on the power stage |
| prebias_i | input | CW | Existing output level expressed as a ramp code |
| sample_req_o | output | 1 | Request to the set-point sampler |
| gate_en_o | output | 1 | Permission for both power-stage gates to switch |
| ref_code_o | output | CW | Reference DAC code |
| in_reg_o | output | 1 | Ramp finished, output in regulation |

## Verification
The main ramp is run with several random pre-bias levels: zero, mid-scale, full scale and a value above full scale. These separate a gate that follows the code compare from one that is simply tied to the ramp state. Overcurrent trips are applied in regulation and at random points of the ramp, and each trip is followed through the whole retry window. This shows whether the retry period is two dummy periods long, whether the ramp restarts from zero, and whether any sample request leaks out during a retry. Enable and bias supply are each removed in mid-sequence to show that only these paths repeat the delay and the sample request.

// File: rtl/softstart_pkg.sv
package softstart_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELAY,
    ST_SAMPLE,
    ST_RAMP,
    ST_REG,
    ST_HICCUP
  } seq_state_e;
endpackage

// File: rtl/ss_timer.sv
module ss_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [TW-1:0] limit_i,
  output logic          hit_o
);
  logic [TW-1:0] cnt_q;

  assign hit_o = en_i && (cnt_q == limit_i - TW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (hit_o)    cnt_q <= '0;
    else if (en_i)     cnt_q <= cnt_q + TW'(1);
  end

  // R4: a running window never passes its limit
  a_r4_cnt_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |-> (cnt_q < limit_i));
endmodule

// File: rtl/ss_ramp.sv
module ss_ramp #(
  parameter int STEPS = 64,
  parameter int CW    = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] code_o,
  output logic          last_o
);
  logic [CW-1:0] code_q;

  assign code_o = code_q;
  assign last_o = (code_q == CW'(STEPS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             code_q <= '0;
    else if (clr_i)                          code_q <= '0;
    else if (inc_i && code_q != CW'(STEPS))  code_q <= code_q + CW'(1);
  end

  // R4: code moves up by at most one step per cycle
  a_r4_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (code_q == $past(code_q) || code_q == $past(code_q) + CW'(1)));
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq #(
  parameter int DELAY_CYC = 68000,
  parameter int STEP_CYC  = 1063,
  parameter int STEPS     = 64,
  localparam int CW       = $clog2(STEPS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          por_ok_i,
  input  logic          en_i,
  input  logic          sample_done_i,
  input  logic          ocp_i,
  input  logic [CW-1:0] prebias_i,
  output logic          sample_req_o,
  output logic          gate_en_o,
  output logic [CW-1:0] ref_code_o,
  output logic          in_reg_o
);
  import softstart_pkg::*;

  localparam int RAMP_CYC = STEPS * STEP_CYC;
  localparam int TMAX     = (DELAY_CYC > RAMP_CYC) ? DELAY_CYC : RAMP_CYC;
  localparam int TW       = $clog2(TMAX + 1);

  seq_state_e    state_q, state_d;
  logic          dummy_q, dummy_d;
  logic          active, running;
  logic          tmr_clr, tmr_en, tmr_hit;
  logic [TW-1:0] tmr_limit;
  logic          ramp_clr, ramp_inc, ramp_last;
  logic [CW-1:0] code;

  assign active  = por_ok_i && en_i;
  assign running = (state_q == ST_RAMP) || (state_q == ST_REG);

  always_comb begin
    state_d  = state_q;
    dummy_d  = dummy_q;
    ramp_inc = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (active) state_d = ST_DELAY;
      ST_DELAY:  if (tmr_hit) state_d = ST_SAMPLE;
      ST_SAMPLE: if (sample_done_i) state_d = ST_RAMP;
      ST_RAMP: begin
        if (ocp_i) begin
          state_d = ST_HICCUP;
          dummy_d = 1'b0;
        end else if (tmr_hit) begin
          ramp_inc = 1'b1;
          if (ramp_last) state_d = ST_REG;
        end
      end
      ST_REG: if (ocp_i) begin
        state_d = ST_HICCUP;
        dummy_d = 1'b0;
      end
      ST_HICCUP: if (tmr_hit) begin
        if (dummy_q) state_d = ST_RAMP;
        else         dummy_d = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    if (!active) state_d = ST_IDLE;
  end

  // code held at zero outside a live ramp; restarts from zero on every ramp entry
  assign ramp_clr = !((state_d == ST_RAMP) || (state_d == ST_REG))
                    || (state_q != ST_RAMP && state_d == ST_RAMP);

  assign tmr_clr = (state_d != state_q);
  assign tmr_en  = (state_q == ST_DELAY) || (state_q == ST_RAMP) || (state_q == ST_HICCUP);

  always_comb begin
    unique case (state_q)
      ST_DELAY:  tmr_limit = TW'(DELAY_CYC);
      ST_RAMP:   tmr_limit = TW'(STEP_CYC);
      ST_HICCUP: tmr_limit = TW'(RAMP_CYC);
      default:   tmr_limit = TW'(1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dummy_q <= 1'b0;
    end else begin
      state_q <= state_d;
      dummy_q <= dummy_d;
    end
  end

  ss_timer #(.TW(TW)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tmr_clr),
    .en_i    (tmr_en),
    .limit_i (tmr_limit),
    .hit_o   (tmr_hit)
  );

  ss_ramp #(.STEPS(STEPS), .CW(CW)) i_ramp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ramp_clr),
    .inc_i  (ramp_inc),
    .code_o (code),
    .last_o (ramp_last)
  );

  assign sample_req_o = (state_q == ST_SAMPLE);
  assign in_reg_o     = (state_q == ST_REG);
  assign ref_code_o   = code;
  // gates cut combinationally on disable or trip; pre-bias only blocks during the ramp
  assign gate_en_o    = active && !ocp_i &&
                        (in_reg_o || (state_q == ST_RAMP && code >= prebias_i));

  a_r4_reg_at_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_reg_o |-> (ref_code_o == CW'(STEPS)));

  a_r6_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!in_reg_o && ref_code_o == '0 && !sample_req_o));

  a_r8_trip_to_retry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ocp_i && active && running) |=> (state_q == ST_HICCUP && ref_code_o == '0));

  a_r8_sample_only_after_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sample_req_o) |-> ($past(state_q) == ST_DELAY));
endmodule

// File: tb/test_softstart_seq.sv
module test_softstart_seq;
  localparam int D  = 20;
  localparam int S  = 3;
  localparam int N  = 64;
  localparam int CW = 7;
  localparam int R  = N * S;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic por = 1'b0, en = 1'b0, done = 1'b0, ocp = 1'b0;
  logic [CW-1:0] prebias = '0;
  logic sample_req, gate_en, in_reg;
  logic [CW-1:0] ref_code;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  softstart_seq #(.DELAY_CYC(D), .STEP_CYC(S), .STEPS(N)) i_softstart_seq (
    .clk_i(clk), .rst_ni(rst_ni), .por_ok_i(por), .en_i(en),
    .sample_done_i(done), .ocp_i(ocp), .prebias_i(prebias),
    .sample_req_o(sample_req), .gate_en_o(gate_en),
    .ref_code_o(ref_code), .in_reg_o(in_reg)
  );

  function automatic int exp_code(int k);
    return k / S;
  endfunction

  function automatic bit exp_gate(int code, int p);
    return code >= p;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #3;
  endtask

  task automatic wait_sample(string req);
    int n = 0;
    bit gate_seen = 0;
    while (!sample_req && n < 1000) begin
      if (gate_en) gate_seen = 1;
      step();
      n++;
    end
    chk(n == D + 1, req, n, D + 1);
    chk(!gate_seen, req, gate_seen, 0);
  endtask

  task automatic run_ramp(int p, int trip_at);
    prebias = CW'(p);
    for (int k = 0; k < R; k++) begin
      if (k == trip_at) begin
        ocp = 1'b1;
        #1;
        chk(!gate_en, "R9 gate cut on trip", gate_en, 0);
        step();
        ocp = 1'b0;
        chk(ref_code == 0 && !in_reg, "R9 ramp aborted", ref_code, 0);
        return;
      end
      #1;
      chk(int'(ref_code) == exp_code(k) && !in_reg, "R4 ramp code", ref_code, exp_code(k));
      chk(gate_en == exp_gate(exp_code(k), p), "R5 pre-bias gate", gate_en, exp_gate(exp_code(k), p));
      step();
    end
    #1;
    chk(in_reg && int'(ref_code) == N, "R4 regulation at full scale", ref_code, N);
    chk(gate_en, "R5 gate on in regulation", gate_en, 1);
  endtask

  task automatic hiccup_run();
    bit bad = 0;
    prebias = '0;
    for (int j = 0; j < 2 * R; j++) begin
      #1;
      if (gate_en || ref_code != 0 || sample_req || in_reg) bad = 1;
      step();
    end
    chk(!bad, "R8 retry window quiet", bad, 0);
    #1;
    chk(ref_code == 0 && gate_en && !sample_req, "R8 ramp restarts", gate_en, 1);
    for (int j = 0; j < S; j++) step();
    chk(ref_code == 1, "R8 restart ramp advancing", ref_code, 1);
    for (int j = 0; j < R - S; j++) step();
    chk(in_reg, "R8 retry reaches regulation", in_reg, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    step(); step();
    chk(!sample_req && !gate_en && !in_reg && ref_code == 0, "R1 reset outputs", ref_code, 0);
    rst_ni = 1'b1;
    step();
    chk(!sample_req && !gate_en && !in_reg && ref_code == 0, "R1 after reset", ref_code, 0);

    en = 1'b1;
    for (int i = 0; i < 5; i++) step();
    chk(!sample_req, "R2 no start without por", sample_req, 0);
    por = 1'b1;
    wait_sample("R2 delay to sample request");

    for (int i = 0; i < 4; i++) step();
    chk(sample_req && ref_code == 0, "R3 request held", sample_req, 1);
    done = 1'b1;
    step();
    done = 1'b0;
    chk(!sample_req, "R3 request released", sample_req, 0);
    run_ramp(17, -1);

    // trip in regulation
    ocp = 1'b1;
    #1;
    chk(!gate_en, "R8 gate cut in regulation", gate_en, 1'b0);
    step();
    ocp = 1'b0;
    hiccup_run();

    // random trips during the ramp: hiccup_run ends in regulation, trip there first
    for (int r = 0; r < 4; r++) begin
      int t, p;
      ocp = 1'b1;
      step();
      ocp = 1'b0;
      for (int j = 0; j < 2 * R; j++) step();
      t = $urandom_range(1, R - 1);
      p = $urandom_range(0, N);
      run_ramp(p, t);
      hiccup_run();
    end

    // pre-bias above full scale
    ocp = 1'b1;
    step();
    ocp = 1'b0;
    for (int j = 0; j < 2 * R; j++) step();
    run_ramp(100, -1);

    // disable and re-enable
    en = 1'b0;
    #1;
    chk(!gate_en, "R6 gate cut on disable", gate_en, 0);
    step();
    chk(!in_reg && ref_code == 0, "R6 cleared after disable", ref_code, 0);
    for (int i = 0; i < 3; i++) step();
    en = 1'b1;
    wait_sample("R6 new sample after enable");
    done = 1'b1;
    step();
    done = 1'b0;
    for (int i = 0; i < 2 * S; i++) step();
    chk(ref_code == 2, "R6 ramp after re-enable", ref_code, 2);

    // bias supply loss mid ramp
    por = 1'b0;
    #1;
    chk(!gate_en, "R7 gate cut on por loss", gate_en, 0);
    step();
    chk(ref_code == 0 && !in_reg, "R7 cleared after por loss", ref_code, 0);
    begin
      bit seen = 0;
      for (int i = 0; i < D + 5; i++) begin
        if (sample_req) seen = 1;
        step();
      end
      chk(!seen, "R7 no request while por low", seen, 0);
    end
    por = 1'b1;
    wait_sample("R7 new sample after por");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule